// File: doc/BRIEF.md
# Programmable Search Key Input Sequencer

This block sits in front of a content-addressable search array and turns a stream of input words into masked 32-bit search keys. Words arrive on a data bus qualified by a strobe, whose active edge is chosen by configuration. Each captured word is one block. A stepped program, stored per channel, decides for every step which blocks feed the key, where a byte-aligned 32-bit window sits in a 64-bit accumulator, which key bits are excluded, and which table segment the search targets.

Two channels each hold eight steps. A sequence reset latches the active channel and the starting step, and it clears the block count and the accumulator. Every step that completes its key emits a one-cycle search request carrying the key, the mask and the segment number. The program runs until a step marked as final, or the last step slot, has fired. From then on, strobes are ignored until the next sequence reset.

Top module: `kis_input_seq`

## Requirements
- R1: `bus_width` selects the block width: 0 selects 32 bits, 1 selects 16 bits (`din[15:0]`), and 2 or 3 select 8 bits (`din[7:0]`). Lanes above the selected width have no effect.
- R2: A block is captured once per active strobe edge. With `edge_pol`=1 the active edge is a 0-to-1 change of `strobe`; with `edge_pol`=0 it is a 1-to-0 change. The strobe is sampled on `clk`.
- R3: Captured blocks are numbered from 0 after each sequence reset. Take the step the pointer is on. A block is kept for that step if the step has already kept a block, or if the block number is at least the step's 6-bit cut field. Earlier blocks are discarded. The step completes when it has kept 64/width blocks: 2, 4 or 8.
- R4: Kept blocks shift into a 64-bit accumulator from the least significant end, so the oldest byte sits in bits 63:56. With window offset n (0 to 3), the key is accumulator bytes n to n+3, counted from the oldest byte, with byte n becoming key bits 31:24.
- R5: A mask bit of 1 excludes that key bit from comparison. The presented key has that bit forced to 0, and `req_mask` carries the step's mask unchanged.
- R6: When a step completes, `req_valid` is high for exactly one cycle, beginning at the clock edge after the one that captured the completing block. `req_seg` carries the step's 3-bit segment number.
- R7: After a step completes, the pointer moves to the next step. If that step has its final flag set, or is step 7, the sequencer halts instead.
- R8: While `seq_rst` is high at a clock edge, the sequencer does four things: it latches `chan_sel` (0 = channel A, 1 = channel B) and `start_step`, clears the block number and the accumulator, leaves the halted state, and emits no request.
- R9: While halted, strobes capture nothing and no request is made. After `rst_n` the sequencer starts halted with `req_valid` low, and it stays halted until the first sequence reset.
- R10: A write with `cfg_we` high stores cut, offset, mask, segment and final flag into step `cfg_step` of channel `cfg_chan` only. The other channel's step of the same number is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Step register write enable |
| cfg_chan | input | 1 | Channel of the step being written |
| cfg_step | input | 3 | Step number being written |
| cfg_cut | input | 6 | First block number the step may keep |
| cfg_offs | input | 2 | Byte offset of the key window |
| cfg_mask | input | 32 | Exclusion mask, 1 = bit ignored |
| cfg_seg | input | 3 | Target segment number |
| cfg_last | input | 1 | Final-step flag |
| bus_width | input | 2 | Block width select |
| edge_pol | input | 1 | Active strobe edge, 1 = rising |
| din | input | 32 | Input data bus |
| strobe | input | 1 | Input write strobe |
| chan_sel | input | 1 | Channel latched at sequence reset |
| start_step | input | 3 | Start step latched at sequence reset |
| seq_rst | input | 1 | Sequence reset |
| req_valid | output | 1 | Search request pulse |
| req_key | output | 32 | Masked search key |
| req_mask | output | 32 | Mask of the request |
| req_seg | output | 3 | Segment number of the request |

## Verification
In one clock edge, the block that completes one step's key can also begin the next step's keeping, when the next step's cut field is already at or below the running block number. The bench provokes this with a step whose cut field is 0, placed after a step that ended on block 6. The final key must then hold blocks 7 and 8. A key built from any other pair shows that the completion and the start of the next step were not handled together. A sequence reset that lands halfway through a key is judged by the first key after it, which must contain only blocks captured after the reset.

// File: rtl/kis_pkg.sv
package kis_pkg;
    parameter int KEY_W   = 32;
    parameter int ACC_W   = 2 * KEY_W;
    parameter int BYTE_W  = 8;
    parameter int NCHAN   = 2;
    parameter int NSTEP   = 8;
    parameter int CUT_W   = 6;
    parameter int SEG_W   = 3;
    parameter int OFFS_W  = 2;

    localparam int CHAN_W  = $clog2(NCHAN);
    localparam int STEP_W  = $clog2(NSTEP);
    localparam int NOFF    = 2 ** OFFS_W;
    localparam int BLK_W   = CUT_W + 1;
    localparam int KEPT_W  = $clog2(ACC_W / BYTE_W) + 1;

    typedef struct packed {
        logic [CUT_W-1:0]  cut;
        logic [OFFS_W-1:0] offs;
        logic [KEY_W-1:0]  mask;
        logic [SEG_W-1:0]  seg;
        logic              last;
    } step_t;

    typedef enum logic [1:0] {
        BW_WORD = 2'd0,
        BW_HALF = 2'd1,
        BW_BYTE = 2'd2,
        BW_BYTE_ALT = 2'd3
    } bus_width_e;
endpackage

// File: rtl/kis_strobe_edge.sv
module kis_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic edge_pol,
    output logic fire
);
    logic stb_d, stb_q;

    always_comb begin
        stb_d = strobe;
        if (edge_pol) fire = strobe & ~stb_q;
        else          fire = ~strobe & stb_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_d;
    end
endmodule

// File: rtl/kis_step_file.sv
module kis_step_file
    import kis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [STEP_W-1:0] wr_step,
    input  step_t             wr_data,
    input  logic [CHAN_W-1:0] rd_chan,
    input  logic [STEP_W-1:0] rd_step,
    output step_t             rd_data
);
    step_t bank_q [NCHAN][NSTEP];

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        step_t row_d [NSTEP];

        always_comb begin
            for (int s = 0; s < NSTEP; s++) begin
                row_d[s] = bank_q[c][s];
                if (wr_en && wr_chan == CHAN_W'(c) && wr_step == STEP_W'(s))
                    row_d[s] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NSTEP; s++) bank_q[c][s] <= '0;
            end else begin
                for (int s = 0; s < NSTEP; s++) bank_q[c][s] <= row_d[s];
            end
        end
    end

    assign rd_data = bank_q[rd_chan][rd_step];
endmodule

// File: rtl/kis_key_window.sv
module kis_key_window
    import kis_pkg::*;
(
    input  logic [ACC_W-1:0]  acc,
    input  logic [OFFS_W-1:0] offs,
    input  logic [KEY_W-1:0]  mask,
    output logic [KEY_W-1:0]  key
);
    logic [KEY_W-1:0] cand [NOFF];

    for (genvar o = 0; o < NOFF; o++) begin : g_win
        assign cand[o] = acc[ACC_W-1-o*BYTE_W -: KEY_W];
    end

    always_comb begin
        key = cand[offs] & ~mask;
    end
endmodule

// File: rtl/kis_input_seq.sv
module kis_input_seq
    import kis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic [CUT_W-1:0]  cfg_cut,
    input  logic [OFFS_W-1:0] cfg_offs,
    input  logic [KEY_W-1:0]  cfg_mask,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              cfg_last,
    input  logic [1:0]        bus_width,
    input  logic              edge_pol,
    input  logic [KEY_W-1:0]  din,
    input  logic              strobe,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic [STEP_W-1:0] start_step,
    input  logic              seq_rst,
    output logic              req_valid,
    output logic [KEY_W-1:0]  req_key,
    output logic [KEY_W-1:0]  req_mask,
    output logic [SEG_W-1:0]  req_seg
);
    localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(2 ** CUT_W);
    localparam int HALF_W = KEY_W / 2;
    localparam int NEED_WORD = ACC_W / KEY_W;
    localparam int NEED_HALF = ACC_W / HALF_W;
    localparam int NEED_BYTE = ACC_W / BYTE_W;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [STEP_W-1:0] ptr;
        logic [BLK_W-1:0]  blk;
        logic [KEPT_W-1:0] kept;
        logic [ACC_W-1:0]  acc;
        logic              halt;
        logic              req_valid;
        logic [KEY_W-1:0]  req_key;
        logic [KEY_W-1:0]  req_mask;
        logic [SEG_W-1:0]  req_seg;
    } seq_state_t;

    seq_state_t st_d, st_q;
    step_t      cur;
    step_t      wr_data;
    logic       fire;
    logic       keep;
    logic [ACC_W-1:0]  acc_ins;
    logic [KEPT_W-1:0] need;
    logic [KEY_W-1:0]  win_key;
    logic              seq_halted;

    assign wr_data = '{cut: cfg_cut, offs: cfg_offs, mask: cfg_mask,
                       seg: cfg_seg, last: cfg_last};

    kis_strobe_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .edge_pol (edge_pol),
        .fire     (fire)
    );

    kis_step_file i_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_chan (cfg_chan),
        .wr_step (cfg_step),
        .wr_data (wr_data),
        .rd_chan (st_q.chan),
        .rd_step (st_q.ptr),
        .rd_data (cur)
    );

    kis_key_window i_win (
        .acc  (acc_ins),
        .offs (cur.offs),
        .mask (cur.mask),
        .key  (win_key)
    );

    // Block width: shift the accumulator by one block and insert the new one
    always_comb begin
        case (bus_width_e'(bus_width))
            BW_WORD: begin
                acc_ins = {st_q.acc[ACC_W-KEY_W-1:0], din};
                need    = KEPT_W'(NEED_WORD);
            end
            BW_HALF: begin
                acc_ins = {st_q.acc[ACC_W-HALF_W-1:0], din[HALF_W-1:0]};
                need    = KEPT_W'(NEED_HALF);
            end
            default: begin
                acc_ins = {st_q.acc[ACC_W-BYTE_W-1:0], din[BYTE_W-1:0]};
                need    = KEPT_W'(NEED_BYTE);
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        st_d.req_valid = 1'b0;
        keep = (st_q.kept != '0) || (st_q.blk >= {1'b0, cur.cut});

        if (seq_rst) begin
            st_d.chan = chan_sel;
            st_d.ptr  = start_step;
            st_d.blk  = '0;
            st_d.kept = '0;
            st_d.acc  = '0;
            st_d.halt = 1'b0;
        end else if (fire && !st_q.halt) begin
            if (st_q.blk != BLK_MAX) st_d.blk = st_q.blk + BLK_W'(1);
            if (keep) begin
                st_d.acc = acc_ins;
                if (st_q.kept + KEPT_W'(1) == need) begin
                    st_d.kept      = '0;
                    st_d.req_valid = 1'b1;
                    st_d.req_key   = win_key;
                    st_d.req_mask  = cur.mask;
                    st_d.req_seg   = cur.seg;
                    if (cur.last || st_q.ptr == STEP_W'(NSTEP - 1))
                        st_d.halt = 1'b1;
                    else
                        st_d.ptr = st_q.ptr + STEP_W'(1);
                end else begin
                    st_d.kept = st_q.kept + KEPT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_halted = st_q.halt;
    assign req_valid  = st_q.req_valid;
    assign req_key    = st_q.req_key;
    assign req_mask   = st_q.req_mask;
    assign req_seg    = st_q.req_seg;
endmodule

// File: rtl/kis_input_seq_chk.sv
module kis_input_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic strobe,
    input logic edge_pol,
    input logic seq_rst,
    input logic seq_halted,
    input logic req_valid
);
    AST_REQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($past(strobe) != $past(strobe, 2)) && ($past(strobe) == $past(edge_pol))); // R2

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!req_valid || ($past(edge_pol) != $past(edge_pol, 2)))); // R6

    AST_SEQRST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rst |=> !req_valid); // R8

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_halted && !seq_rst) |=> !req_valid); // R9
endmodule

bind kis_input_seq kis_input_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .edge_pol   (edge_pol),
    .seq_rst    (seq_rst),
    .seq_halted (seq_halted),
    .req_valid  (req_valid)
);

// File: tb/test_kis_input_seq.sv
module test_kis_input_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_chan = '0;
    logic [2:0]  cfg_step = '0;
    logic [5:0]  cfg_cut = '0;
    logic [1:0]  cfg_offs = '0;
    logic [31:0] cfg_mask = '0;
    logic [2:0]  cfg_seg = '0;
    logic        cfg_last = 1'b0;
    logic [1:0]  bus_width = 2'd0;
    logic        edge_pol = 1'b1;
    logic [31:0] din = '0;
    logic        strobe = 1'b0;
    logic [0:0]  chan_sel = '0;
    logic [2:0]  start_step = '0;
    logic        seq_rst = 1'b0;
    logic        req_valid;
    logic [31:0] req_key, req_mask;
    logic [2:0]  req_seg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int          ev_n = 0;
    logic [31:0] ev_key  [64];
    logic [31:0] ev_mask [64];
    logic [2:0]  ev_seg  [64];

    always #2.5 clk = ~clk;

    kis_input_seq i_kis_input_seq (.*);

    always @(negedge clk) begin
        if (rst_n && req_valid && ev_n < 64) begin
            ev_key[ev_n]  = req_key;
            ev_mask[ev_n] = req_mask;
            ev_seg[ev_n]  = {29'd0, req_seg} [2:0];
            ev_n = ev_n + 1;
        end
    end

    typedef struct packed {
        logic [5:0]  cut;
        logic [1:0]  offs;
        logic [31:0] mask;
        logic [2:0]  seg;
        logic        last;
        logic [31:0] exp_key;
    } vec_t;

    // Channel A program with 32-bit blocks; block i carries bytes i1 i2 i3 i4
    localparam vec_t TBL [4] = '{
        '{6'd0, 2'd0, 32'h0000_0000, 3'd1, 1'b0, 32'h0102_0304},
        '{6'd3, 2'd1, 32'h0000_00FF, 3'd2, 1'b0, 32'h3233_3400},
        '{6'd5, 2'd3, 32'hF000_0000, 3'd7, 1'b0, 32'h0461_6263},
        '{6'd0, 2'd2, 32'h0000_0000, 3'd0, 1'b1, 32'h7374_8182}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic prog(input logic ch, input logic [2:0] st, input logic [5:0] cut,
                        input logic [1:0] offs, input logic [31:0] mask,
                        input logic [2:0] seg, input logic last);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_step = st; cfg_cut = cut;
        cfg_offs = offs; cfg_mask = mask; cfg_seg = seg; cfg_last = last;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic seqrst(input logic ch, input logic [2:0] st);
        @(negedge clk);
        chan_sel = ch; start_step = st; seq_rst = 1'b1;
        @(negedge clk);
        seq_rst = 1'b0;
    endtask

    task automatic send(input logic [31:0] d);
        @(negedge clk);
        din = d;
        strobe = edge_pol;
        @(negedge clk);
        strobe = ~edge_pol;
    endtask

    function automatic logic [31:0] blk32(input int i);
        logic [3:0] n = 4'(i);
        return {n, 4'h1, n, 4'h2, n, 4'h3, n, 4'h4};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk("R9 reset req_valid low", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;

        // Program channel A steps 0..3 from the table
        foreach (TBL[k])
            prog(1'b0, 3'(k), TBL[k].cut, TBL[k].offs, TBL[k].mask, TBL[k].seg, TBL[k].last);

        // R9: halted after reset until the first sequence reset
        send(blk32(0)); send(blk32(1)); send(blk32(2));
        repeat (2) @(negedge clk);
        chk("R9 strobes before first seq_rst ignored", ev_n, 0);

        // R3 R4 R5 R6 R7: table walk, 32-bit blocks, rising edges
        seqrst(1'b0, 3'd0);
        base = ev_n;
        for (int i = 0; i < 10; i++) send(blk32(i));
        repeat (2) @(negedge clk);
        chk("R7 four requests then halt, block 9 ignored", ev_n - base, 4);
        foreach (TBL[k]) begin
            chk($sformatf("R4 R5 key of step %0d", k), ev_key[base + k], TBL[k].exp_key);
            chk($sformatf("R5 mask of step %0d", k), ev_mask[base + k], TBL[k].mask);
            chk($sformatf("R6 segment of step %0d", k), {29'd0, ev_seg[base + k]}, {29'd0, TBL[k].seg});
        end

        // R1 R2 R10: channel B step 2, 8-bit blocks, falling edges, upper lanes garbage
        prog(1'b1, 3'd2, 6'd1, 2'd2, 32'h0, 3'd5, 1'b1);
        strobe = 1'b1;
        @(negedge clk);
        edge_pol = 1'b0;
        bus_width = 2'd2;
        seqrst(1'b1, 3'd2);
        base = ev_n;
        for (int i = 0; i < 10; i++) send({24'hABCDEF, 8'hC0 + 8'(i)});
        repeat (2) @(negedge clk);
        chk("R2 R3 one request on falling edges, block 0 cut", ev_n - base, 1);
        chk("R1 R10 8-bit key from channel B step 2", ev_key[base], 32'hC3C4_C5C6);
        chk("R10 channel B segment", {29'd0, ev_seg[base]}, 32'd5);

        // R1: 16-bit blocks, back to rising edges, channel A step 3
        strobe = 1'b0;
        @(negedge clk);
        edge_pol = 1'b1;
        bus_width = 2'd1;
        seqrst(1'b0, 3'd3);
        base = ev_n;
        send({16'h5555, 16'hA1A2}); send({16'h5555, 16'hB1B2});
        send({16'h5555, 16'hC1C2}); send({16'h5555, 16'hD1D2});
        send({16'h5555, 16'hE1E2});
        repeat (2) @(negedge clk);
        chk("R1 R7 16-bit single request", ev_n - base, 1);
        chk("R1 16-bit key offset 2", ev_key[base], 32'hB1B2_C1C2);
        chk("R10 channel A step 3 unchanged by channel B write", {29'd0, ev_seg[base]}, 32'd0);

        // R7: step 7 without final flag still halts
        prog(1'b0, 3'd7, 6'd0, 2'd0, 32'hFFFF_0000, 3'd3, 1'b0);
        bus_width = 2'd0;
        seqrst(1'b0, 3'd7);
        base = ev_n;
        send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333); send(32'h4444_4444);
        repeat (2) @(negedge clk);
        chk("R7 step 7 halts after one request", ev_n - base, 1);
        chk("R5 masked key step 7", ev_key[base], 32'h0000_1111);
        chk("R6 segment step 7", {29'd0, ev_seg[base]}, 32'd3);

        // R8: sequence reset in the middle of a key discards earlier blocks
        seqrst(1'b0, 3'd0);
        base = ev_n;
        send(32'hDEAD_BEEF);
        seqrst(1'b0, 3'd0);
        send(32'h1234_5678); send(32'h9ABC_DEF0);
        repeat (2) @(negedge clk);
        chk("R8 one request after mid-key reset", ev_n - base, 1);
        chk("R8 key built only from post-reset blocks", ev_key[base], 32'h1234_5678);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule